// File: doc/BRIEF.md
# Time-of-Day Register Front End

This block sits between a 32-bit memory-mapped register bus and a running time-of-day counter. The counter keeps a 48-bit seconds value and a 30-bit nanoseconds value. Software cannot read either value in a single bus access, so the block makes a multi-word read coherent. A read of the nanoseconds word returns the live nanoseconds and, in the same clock edge, freezes a copy of the live seconds. Later reads of the two seconds words return that frozen copy.

Loading a new time works the other way round. Software first writes the seconds-high word, then the seconds-low word. Both writes only fill staging registers. The final write to the nanoseconds word hands the whole time to the counter at once, together with a single-cycle load strobe. The counter treats that strobe as taking priority over its normal increment in that cycle.

A read-only word reports the counter's input clock rate in hertz. The counter arithmetic itself, period tuning and drift correction live in other blocks.

Top module: `tod_reg_front`

## Requirements
- R1: After reset, bus_rdata, bus_rvalid and load_strobe are 0 and load_sec and load_ns are 0. Until the first nanoseconds read, reads of either seconds word return 0 whatever the live seconds are.
- R2: A read at offset 0x108 (nanoseconds) returns {2'b00, live_ns} as sampled at the clock edge that accepts the read.
- R3: The same edge that accepts a nanoseconds read captures live_sec. Reads at 0x104 (seconds-low, seconds bits 31:0) return the value from that capture, even after live_sec has changed.
- R4: A read at 0x100 (seconds-high) returns captured seconds bits 47:32 in data bits 15:0, with data bits 31:16 reading as 0.
- R5: A write to 0x100 or 0x104 does not assert load_strobe and leaves load_sec and load_ns unchanged.
- R6: A write to 0x108 asserts load_strobe in the cycle after the write edge. In that cycle load_sec is {staged high bits 15:0, staged low word} and load_ns is wdata bits 29:0. Staged seconds persist, so a further nanoseconds write reuses them.
- R7: Data bits 31:16 of a seconds-high write are ignored.
- R8: A read at 0x038 returns the CLK_HZ parameter, and a write there has no effect.
- R9: A read at any other offset returns 0.
- R10: bus_rvalid is 1 exactly in the cycle after each read is accepted (bus_rd high at an edge) and is 0 otherwise. bus_rdata holds the read result in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write request for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read request for this cycle |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| live_sec | input | 48 | Running seconds from the counter |
| live_ns | input | 30 | Running nanoseconds from the counter |
| load_strobe | output | 1 | One-cycle request to load the staged time |
| load_sec | output | 48 | Seconds to load |
| load_ns | output | 30 | Nanoseconds to load |

## Verification
The assertions assume that bus_rd and bus_wr are held low during reset. They also assume that at most one write reaches a given offset per cycle, which holds because the address decode selects a single word. The stimulus drives every bus and live input on the falling clock edge and keeps them steady across the rising edge. It also changes the live time only between accesses, so each capture sees a defined value. Two commits are never issued back to back, which keeps the check that load outputs stay stable between strobes meaningful.

// File: rtl/tod_if_pkg.sv
package tod_if_pkg;
  localparam int unsigned BUS_W    = 32;
  localparam int unsigned SEC_W    = 48;
  localparam int unsigned NS_W     = 30;
  localparam int unsigned SEC_HI_W = SEC_W - BUS_W;

  // software-visible word offsets
  localparam int unsigned OFS_FREQ   = 32'h038;
  localparam int unsigned OFS_SEC_HI = 32'h100;
  localparam int unsigned OFS_SEC_LO = 32'h104;
  localparam int unsigned OFS_NSEC   = 32'h108;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_FREQ,
    SEL_SEC_HI,
    SEL_SEC_LO,
    SEL_NSEC
  } word_sel_e;

  function automatic word_sel_e pick_word(input logic [31:0] ofs);
    if (ofs == OFS_FREQ)        return SEL_FREQ;
    else if (ofs == OFS_SEC_HI) return SEL_SEC_HI;
    else if (ofs == OFS_SEC_LO) return SEL_SEC_LO;
    else if (ofs == OFS_NSEC)   return SEL_NSEC;
    else                        return SEL_NONE;
  endfunction

  function automatic logic [BUS_W-1:0] upper_sec_word(input logic [SEC_W-1:0] s);
    return {{(BUS_W-SEC_HI_W){1'b0}}, s[SEC_W-1:BUS_W]};
  endfunction

  function automatic logic [SEC_W-1:0] merge_sec(input logic [SEC_HI_W-1:0] hi,
                                                 input logic [BUS_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [BUS_W-1:0] nsec_word(input logic [NS_W-1:0] n);
    return {{(BUS_W-NS_W){1'b0}}, n};
  endfunction
endpackage

// File: rtl/tod_word_decode.sv
module tod_word_decode
  import tod_if_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output word_sel_e         sel,
  output logic              wr_hi,
  output logic              wr_lo,
  output logic              wr_ns,
  output logic              rd_ns
);
  always_comb begin
    sel   = pick_word(32'(addr));
    wr_hi = wr && (sel == SEL_SEC_HI);
    wr_lo = wr && (sel == SEL_SEC_LO);
    wr_ns = wr && (sel == SEL_NSEC);
    rd_ns = rd && (sel == SEL_NSEC);
  end

  // at most one write target per cycle
  always_comb begin
    single_wr_chk: assert ($countones({wr_hi, wr_lo, wr_ns}) <= 1);
  end
endmodule

// File: rtl/tod_capture.sv
module tod_capture
  import tod_if_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [SEC_W-1:0] live_sec,
  output logic [SEC_W-1:0] held_sec
);
  always_ff @(posedge clk) begin
    if (!rst_n)    held_sec <= '0;
    else if (take) held_sec <= live_sec;
  end

  // R3
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(held_sec));
  // R3
  capture_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (held_sec == $past(live_sec)));
endmodule

// File: rtl/tod_stage.sv
module tod_stage
  import tod_if_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hi,
  input  logic             wr_lo,
  input  logic             wr_ns,
  input  logic [BUS_W-1:0] wdata,
  output logic             load_strobe,
  output logic [SEC_W-1:0] load_sec,
  output logic [NS_W-1:0]  load_ns
);
  logic [SEC_HI_W-1:0] stage_hi;
  logic [BUS_W-1:0]    stage_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_hi    <= '0;
      stage_lo    <= '0;
      load_strobe <= 1'b0;
      load_sec    <= '0;
      load_ns     <= '0;
    end else begin
      load_strobe <= wr_ns;
      if (wr_hi) stage_hi <= wdata[SEC_HI_W-1:0];
      if (wr_lo) stage_lo <= wdata;
      if (wr_ns) begin
        load_sec <= merge_sec(stage_hi, stage_lo);
        load_ns  <= wdata[NS_W-1:0];
      end
    end
  end

  // R5
  load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_strobe |-> ($stable(load_sec) && $stable(load_ns)));
  // R6
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ns |=> load_strobe);
  // R5
  no_stage_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi || wr_lo) |=> !load_strobe);
endmodule

// File: rtl/tod_read_port.sv
module tod_read_port
  import tod_if_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd,
  input  word_sel_e        sel,
  input  logic [NS_W-1:0]  live_ns,
  input  logic [SEC_W-1:0] held_sec,
  output logic [BUS_W-1:0] rdata,
  output logic             rvalid
);
  localparam logic [BUS_W-1:0] FREQ_WORD = BUS_W'(CLK_HZ);

  logic rd_hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata   <= '0;
      rvalid  <= 1'b0;
      rd_hi_q <= 1'b0;
    end else begin
      rvalid  <= rd;
      rd_hi_q <= rd && (sel == SEL_SEC_HI);
      if (rd) begin
        unique case (sel)
          SEL_FREQ:   rdata <= FREQ_WORD;
          SEL_SEC_HI: rdata <= upper_sec_word(held_sec);
          SEL_SEC_LO: rdata <= held_sec[BUS_W-1:0];
          SEL_NSEC:   rdata <= nsec_word(live_ns);
          default:    rdata <= '0;
        endcase
      end
    end
  end

  // R10
  rvalid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rvalid);
  // R10
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rvalid);
  // R4
  hi_zero_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && rd_hi_q) |-> (rdata[BUS_W-1:SEC_HI_W] == '0));
endmodule

// File: rtl/tod_reg_front.sv
module tod_reg_front
  import tod_if_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [47:0]       live_sec,
  input  logic [29:0]       live_ns,
  output logic              load_strobe,
  output logic [47:0]       load_sec,
  output logic [29:0]       load_ns
);
  word_sel_e        sel;
  logic             wr_hi, wr_lo, wr_ns, rd_ns;
  logic [SEC_W-1:0] held_sec;

  tod_word_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .sel(sel),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_ns(wr_ns), .rd_ns(rd_ns)
  );

  tod_capture u_cap (
    .clk(clk), .rst_n(rst_n), .take(rd_ns),
    .live_sec(live_sec), .held_sec(held_sec)
  );

  tod_stage u_stage (
    .clk(clk), .rst_n(rst_n), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_ns(wr_ns),
    .wdata(bus_wdata), .load_strobe(load_strobe),
    .load_sec(load_sec), .load_ns(load_ns)
  );

  tod_read_port #(.CLK_HZ(CLK_HZ)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .sel(sel),
    .live_ns(live_ns), .held_sec(held_sec),
    .rdata(bus_rdata), .rvalid(bus_rvalid)
  );

  // R6
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_strobe |-> $past(bus_wr && (32'(bus_addr) == OFS_NSEC)));
endmodule

// File: tb/sim_tod_reg_front.sv
module sim_tod_reg_front;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned HZ = 156_250_000;
  localparam int WATCHDOG = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [47:0] live_sec = '0;
  logic [29:0] live_ns = '0;
  logic        load_strobe;
  logic [47:0] load_sec;
  logic [29:0] load_ns;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_reg_front #(.ADDR_W(12), .CLK_HZ(HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .live_sec(live_sec), .live_ns(live_ns),
    .load_strobe(load_strobe), .load_sec(load_sec), .load_ns(load_ns)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pop expected read data as results appear
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected rvalid", 64'd1, 64'd0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, 64'(bus_rdata), 64'(e));
      end
    end
  end

  task automatic do_read(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_addr = a;
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rdata", 64'(bus_rdata), 64'd0);
    check("R1 rvalid", 64'(bus_rvalid), 64'd0);
    check("R1 strobe", 64'(load_strobe), 64'd0);
    check("R1 load_sec", 64'(load_sec), 64'd0);
    check("R1 load_ns", 64'(load_ns), 64'd0);
    rst_n = 1'b1;
    live_sec = 48'h1234_89AB_CDEF;
    live_ns  = 30'h1ABC_DEF0;
    // R1 seconds read zero before any capture
    do_read(12'h104, 32'h0, "R1 sec lo before capture");
    do_read(12'h100, 32'h0, "R1 sec hi before capture");
    // R10 rvalid drops after a single read
    @(negedge clk);
    check("R10 rvalid idle", 64'(bus_rvalid), 64'd0);
    // R2 / R3 / R4 coherent capture
    do_read(12'h108, 32'h1ABC_DEF0, "R2 nsec read");
    live_sec = 48'hFFFF_0000_0001;
    live_ns  = 30'h0000_0005;
    do_read(12'h104, 32'h89AB_CDEF, "R3 sec lo from capture");
    do_read(12'h100, 32'h0000_1234, "R4 sec hi from capture");
    do_read(12'h108, 32'h0000_0005, "R2 second nsec read");
    do_read(12'h100, 32'h0000_FFFF, "R4 sec hi all ones, upper zero");
    do_read(12'h104, 32'h0000_0001, "R3 sec lo new capture");
    // R8 frequency word
    do_read(12'h038, HZ, "R8 freq read");
    do_write(12'h038, 32'hDEAD_BEEF);
    do_read(12'h038, HZ, "R8 freq after write");
    // R9 unmapped
    do_read(12'h10C, 32'h0, "R9 unmapped 0x10C");
    do_read(12'h000, 32'h0, "R9 unmapped 0x000");
    // R5 / R7 staging writes
    do_write(12'h100, 32'hFFFF_00A5);
    check("R5 no strobe on hi write", 64'(load_strobe), 64'd0);
    check("R5 load_sec unchanged", 64'(load_sec), 64'd0);
    do_write(12'h104, 32'h1111_2222);
    check("R5 no strobe on lo write", 64'(load_strobe), 64'd0);
    check("R5 load_ns unchanged", 64'(load_ns), 64'd0);
    // R6 commit
    do_write(12'h108, 32'hC000_0007);
    check("R6 strobe", 64'(load_strobe), 64'd1);
    check("R6 R7 load_sec", 64'(load_sec), 64'h0000_00A5_1111_2222);
    check("R6 load_ns", 64'(load_ns), 64'h7);
    @(negedge clk);
    check("R6 strobe one cycle", 64'(load_strobe), 64'd0);
    // R6 staged seconds reused on second commit
    do_write(12'h108, 32'h3B9A_C9FF);
    check("R6 second strobe", 64'(load_strobe), 64'd1);
    check("R6 reused sec", 64'(load_sec), 64'h0000_00A5_1111_2222);
    check("R6 second ns", 64'(load_ns), 64'h3B9A_C9FF);
    @(negedge clk);
    // R3 writes leave the captured seconds alone
    do_read(12'h104, 32'h0000_0001, "R3 capture after writes");
    repeat (3) @(negedge clk);
    check("R10 queue drained", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    report();
  end
endmodule